// File: doc/BRIEF.md
# Serial ROM Addressing and Search Engine

This block is the device-selection layer of a single-wire slave. After every bus reset it collects one command byte from the time-slot layer and then serves the device's 64-bit identity in one of several ways. It can stream the identity out, compare it against an identity the master sends, select the device without any addressing, or take part in a bitwise binary-tree search. A conditional variant of the search joins only when an external condition input is high.

The interface toward the time-slot layer works one bit at a time. A one-cycle `rx_valid` strobe delivers a bit the master wrote. `tx_req` with `tx_bit` offers a bit for the next read slot, and that bit is consumed by a one-cycle `tx_ack` strobe. A `bus_reset` pulse marks a detected reset. The `selected` output tells the following command layer that this device has been addressed. The identity is a parameter. Its low byte is the family code, the next six bytes are the serial number, and the top byte is the check byte.

Top module: `rom_select_engine`

## Requirements
- R1: After `rst_n` the engine has `selected`=0 and `tx_req`=0, and it ignores all received bits until the first `bus_reset`.
- R2: A `bus_reset` pulse at any point deselects the device, clears `tx_req` and returns the engine to collecting a command byte.
- R3: The command byte is received as 8 bits, least significant bit first. Any change of `selected` from 0 to 1 happens only on a cycle that carries an `rx_valid` or `tx_ack` strobe.
- R4: Command 33h makes the engine offer the 64 identity bits in order from bit 0 to bit 63, one per `tx_ack`. After the last bit, `selected`=1 and `tx_req`=0.
- R5: Command 55h makes the engine take 64 bits from the master, bit 0 first. `selected` becomes 1 only if every bit equals the identity. On the first differing bit the engine goes idle with `tx_req`=0 until the next `bus_reset`.
- R6: Command CCh sets `selected`=1 at once, with nothing sent.
- R7: Command F0h starts a search. For each identity bit from 0 to 63, the engine offers the bit, then offers its complement, then takes the master's bit. After 64 equal bits, `selected`=1.
- R8: During a search, a master bit that differs from the identity bit sends the engine idle until the next `bus_reset`. It then has `tx_req`=0 and `selected`=0.
- R9: Command ECh behaves as F0h when `cond_ok` is 1 on the final command bit. Otherwise the engine goes idle with no output.
- R10: Any other command byte sends the engine idle until the next `bus_reset`.
- R11: While `tx_req`=1 and no `tx_ack` or `bus_reset` arrives, `tx_req` stays 1 and `tx_bit` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: bus reset detected |
| rx_valid | input | 1 | One-cycle strobe: master bit available |
| rx_bit | input | 1 | Bit written by the master |
| tx_ack | input | 1 | One-cycle strobe: offered bit was read |
| cond_ok | input | 1 | Condition for the conditional search |
| tx_req | output | 1 | Engine offers a bit for the next read slot |
| tx_bit | output | 1 | Bit offered |
| selected | output | 1 | Device is addressed |

## Verification
Every command code is walked once, including the conditional search under both condition levels and two unknown bytes. Each one shows whether it lands in a sending, receiving, selected or dead state. The identity is then checked bit by bit through a read, a full match and a full search. Each of these sees a wrong bit order or an inverted complement. A match that differs at bit 40 and a search that differs at bit 5 show that a late or early mismatch drops the device. A reset in the middle of a read, and bits sent before the first bus reset, show the two ways the engine is forced back to a known state.

// File: rtl/rom_select_engine.sv
module rom_select_engine #(
  parameter logic [63:0] ROM_ID = 64'h5E00_0001_2345_6712
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_ack,
  input  logic cond_ok,
  output logic tx_req,
  output logic tx_bit,
  output logic selected
);
  localparam int IdBits = 64;
  localparam int IdxW = $clog2(IdBits);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(IdBits - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_S_TRUE, ST_S_COMP, ST_S_MASTER, ST_DONE
  } state_t;

  state_t state;
  logic [IdxW-1:0] idx;
  logic [7:0] cmd;
  logic [7:0] cmd_next;
  logic id_bit;
  logic last;

  assign cmd_next = {rx_bit, cmd[7:1]};
  assign id_bit   = ROM_ID[idx];
  assign last     = (idx == LastIdx);
  assign tx_req   = (state == ST_READ) || (state == ST_S_TRUE) || (state == ST_S_COMP);
  assign tx_bit   = (state == ST_S_COMP) ? ~id_bit : id_bit;
  assign selected = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      cmd   <= '0;
    end else if (bus_reset) begin
      state <= ST_CMD;
      idx   <= '0;
    end else begin
      case (state)
        ST_CMD: if (rx_valid) begin
          cmd <= cmd_next;
          idx <= idx + 1'b1;
          if (idx == IdxW'(7)) begin
            idx <= '0;
            case (cmd_next)
              8'h33: state <= ST_READ;
              8'h55: state <= ST_MATCH;
              8'hCC: state <= ST_DONE;
              8'hF0: state <= ST_S_TRUE;
              8'hEC: state <= cond_ok ? ST_S_TRUE : ST_IDLE;
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_READ: if (tx_ack) begin
          idx <= idx + 1'b1;
          if (last) state <= ST_DONE;
        end
        ST_MATCH: if (rx_valid) begin
          idx <= idx + 1'b1;
          if (rx_bit != id_bit) state <= ST_IDLE;
          else if (last) state <= ST_DONE;
        end
        ST_S_TRUE: if (tx_ack) state <= ST_S_COMP;
        ST_S_COMP: if (tx_ack) state <= ST_S_MASTER;
        ST_S_MASTER: if (rx_valid) begin
          idx <= idx + 1'b1;
          if (rx_bit != id_bit) state <= ST_IDLE;
          else if (last) state <= ST_DONE;
          else state <= ST_S_TRUE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rom_select_engine_chk.sv
module rom_select_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic rx_valid,
  input logic tx_ack,
  input logic tx_req,
  input logic tx_bit,
  input logic selected
);
  assert_sel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> !tx_req);

  assert_reset_deselects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && !tx_req));

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ack && !bus_reset) |=> (tx_req && $stable(tx_bit)));

  assert_sel_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(rx_valid || tx_ack));
endmodule

bind rom_select_engine rom_select_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
  .tx_ack(tx_ack), .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected)
);

// File: tb/rom_select_engine_test.sv
module rom_select_engine_test;
  localparam int ClkPeriod = 10;
  localparam logic [63:0] Id = 64'h5E00_0001_2345_6712;

  logic clk = 0, rst_n = 0, bus_reset = 0, rx_valid = 0, rx_bit = 0, tx_ack = 0, cond_ok = 0;
  logic tx_req, tx_bit, selected;
  int checks = 0, failures = 0;

  rom_select_engine #(.ROM_ID(Id)) uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tx_ack(tx_ack), .cond_ok(cond_ok), .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected)
  );

  always #(ClkPeriod/2) clk = ~clk;

  // {cmd, cond, exp_tx_req, exp_selected}
  localparam logic [10:0] Vec [8] = '{
    {8'h33, 1'b0, 1'b1, 1'b0}, {8'h55, 1'b0, 1'b0, 1'b0},
    {8'hF0, 1'b0, 1'b1, 1'b0}, {8'hEC, 1'b1, 1'b1, 1'b0},
    {8'hEC, 1'b0, 1'b0, 1'b0}, {8'hCC, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b0, 1'b0}, {8'hFF, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1; @(negedge clk); bus_reset = 0;
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); rx_valid = 1; rx_bit = b; @(negedge clk); rx_valid = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic get_bit(output logic b, output logic req);
    @(negedge clk); b = tx_bit; req = tx_req; tx_ack = 1; @(negedge clk); tx_ack = 0;
  endtask

  initial begin
    #(ClkPeriod * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic b, r, ok, okr;
    repeat (3) @(negedge clk);
    check("R1 reset state", {tx_req, selected}, 2'b00);
    rst_n = 1;
    put_byte(8'hCC);
    check("R1 bits ignored before bus reset", {tx_req, selected}, 2'b00);

    foreach (Vec[k]) begin
      pulse_reset();
      cond_ok = Vec[k][2];
      put_byte(Vec[k][10:3]);
      check($sformatf("R3 R9 R10 command %h", Vec[k][10:3]), {tx_req, selected}, Vec[k][1:0]);
    end

    // R4 read ROM
    pulse_reset(); put_byte(8'h33);
    ok = 1; okr = 1;
    for (int i = 0; i < 64; i++) begin
      get_bit(b, r);
      if (b !== Id[i]) ok = 0;
      if (r !== 1'b1) okr = 0;
    end
    check("R4 read bits", {ok, okr}, 2'b11);
    check("R4 read then selected", {tx_req, selected}, 2'b01);

    // R2 reset mid-read
    pulse_reset(); put_byte(8'h33);
    for (int i = 0; i < 10; i++) get_bit(b, r);
    pulse_reset();
    check("R2 reset mid-read", {tx_req, selected}, 2'b00);
    put_byte(8'hCC);
    check("R2 command after reset R6", {tx_req, selected}, 2'b01);

    // R5 match
    pulse_reset(); put_byte(8'h55);
    for (int i = 0; i < 64; i++) put_bit(Id[i]);
    check("R5 full match", {tx_req, selected}, 2'b01);
    pulse_reset(); put_byte(8'h55);
    for (int i = 0; i < 64; i++) put_bit(i == 40 ? ~Id[i] : Id[i]);
    check("R5 mismatch at bit 40", {tx_req, selected}, 2'b00);

    // R7 search
    pulse_reset(); put_byte(8'hF0);
    ok = 1;
    for (int i = 0; i < 64; i++) begin
      get_bit(b, r); if (b !== Id[i] || r !== 1'b1) ok = 0;
      get_bit(b, r); if (b !== ~Id[i] || r !== 1'b1) ok = 0;
      put_bit(Id[i]);
    end
    check("R7 search bit and complement", {ok, 1'b1}, 2'b11);
    check("R7 search completes selected", {tx_req, selected}, 2'b01);

    // R8 search mismatch
    pulse_reset(); put_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      get_bit(b, r); get_bit(b, r);
      put_bit(i == 5 ? ~Id[i] : Id[i]);
    end
    check("R8 search mismatch idle", {tx_req, selected}, 2'b00);
    put_byte(8'hCC);
    check("R8 stays idle until reset", {tx_req, selected}, 2'b00);

    // R9 conditional search full run
    pulse_reset(); cond_ok = 1; put_byte(8'hEC); cond_ok = 0;
    for (int i = 0; i < 64; i++) begin
      get_bit(b, r); get_bit(b, r); put_bit(Id[i]);
    end
    check("R9 conditional search selects", {tx_req, selected}, 2'b01);

    // R11 hold with no ack
    pulse_reset(); put_byte(8'h33);
    get_bit(b, r);
    repeat (5) @(negedge clk);
    check("R11 offered bit held", {tx_req, tx_bit}, {1'b1, Id[1]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule